// File: doc/BRIEF.md
# Self-Addressing I2C Control Register Bank

This block is a write-only I2C target that sets the control state of a stereo analog front end: per-channel attenuation and mute, input line and input gain, a set of power-down flags, and the output-stage, mixing and serial audio format controls. The target answers one fixed 7-bit address. After the address, it decodes each data byte by that byte's own leading bits. There is no register pointer, so every byte names the register it writes. One transaction may hold any number of such bytes, and each byte lands in its own register.

SCL and SDA are sampled by a faster system clock. Both pass through a synchroniser, and edge detection finds START, STOP and the clock edges. The target only pulls SDA low for the acknowledge clock. It never reads back and never stretches the clock.

Top module: `i2c_ctl_bank`

## Requirements
- R1: After reset: left attenuation field 3Fh with mute on, right attenuation field 3Fh with mute on, both gain fields 0, both line selects 0 (line 1), all five power flags 1, and all mode outputs 0.
- R2: Bits clocked on the bus with no START before them are ignored. Register outputs change only in the cycle after an accepted data byte.
- R3: The address byte 88h (address 1000100, write bit 0) is acknowledged: sda_oe_o is high through the ninth SCL pulse.
- R4: Any other first byte, including 89h (read), gets no acknowledge, and the data bytes that follow it up to the next START are ignored.
- R5: A data byte 00xxxxxx writes bits 5:0 to the left attenuation field (bits 5:3 coarse 10 dB steps, bits 2:0 fine 1.25 dB steps). A byte 01xxxxxx writes the right field. A field is muted exactly when it holds 111111.
- R6: A data byte 100ggg ss sets left gain = bits 4:2 (3 dB steps) and left line select = bits 1:0 (00 = line 1 to 11 = line 4). A byte 101ggg ss sets the right equivalents.
- R7: A data byte 110xxxxx sets the flags from bit 4 down to bit 0: DAC power-down, right power-down, left power-down, power-off preparation, reference-pin pull-down.
- R8: A data byte 111xxxxx sets the following. Bit 4: single-ended output (1) or bridged output (0). Bit 3: mix left. Bit 2: mix right. Bits 1:0: format (00 right-justified, 10 left-justified, 01 I2S).
- R9: Any number of data bytes may follow the address in one transaction. Each one is acknowledged and applied in order.
- R10: A repeated START in the middle of a byte throws away the partial byte and begins a new address phase.
- R11: sda_oe_o changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line (resolved bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| att_l_o | output | 6 | Left attenuation code |
| att_r_o | output | 6 | Right attenuation code |
| mute_l_o | output | 1 | Left channel muted |
| mute_r_o | output | 1 | Right channel muted |
| gain_l_o | output | 3 | Left input gain code |
| sel_l_o | output | 2 | Left input line select |
| gain_r_o | output | 3 | Right input gain code |
| sel_r_o | output | 2 | Right input line select |
| dac_pd_o | output | 1 | DAC power-down |
| rpd_o | output | 1 | Right amplifier power-down |
| lpd_o | output | 1 | Left amplifier power-down |
| off_prep_o | output | 1 | Power-off preparation |
| ref_pd_o | output | 1 | Reference pin pull-down |
| se_mode_o | output | 1 | Single-ended output mode |
| mix_l_o | output | 1 | Mix DAC into left path |
| mix_r_o | output | 1 | Mix DAC into right path |
| fmt_o | output | 2 | Serial audio format code |

## Verification
Directed transactions write a single byte of each prefix. They check field placement and the boundary between mute and the largest non-mute code, so a swapped prefix or a shifted field shows up. Foreign and read addresses, stray bits with no START before them, and a repeated START partway through a byte each check that nothing is written, which separates rejection from acceptance. Random multi-byte transactions from a fixed seed, with an occasional bad address, check the acknowledge on every byte against a byte-by-byte model. They also catch any overwrite between registers and any loss of ordering.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int ATT_W    = 6;
    localparam int FIELD_W  = 5;
    localparam logic [BYTE_W-1:0] TGT_ADDR_BYTE = 8'h88;

    localparam logic [ATT_W-1:0]   ATT_RST  = 6'h3F;
    localparam logic [FIELD_W-1:0] GSEL_RST = 5'h00;
    localparam logic [FIELD_W-1:0] PWR_RST  = 5'h1F;
    localparam logic [FIELD_W-1:0] MODE_RST = 5'h00;

    typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK} rx_state_e;

    typedef struct packed {
        logic [ATT_W-1:0]   att_l;
        logic [ATT_W-1:0]   att_r;
        logic [FIELD_W-1:0] gsel_l;
        logic [FIELD_W-1:0] gsel_r;
        logic [FIELD_W-1:0] pwr;
        logic [FIELD_W-1:0] mode;
    } ctl_regs_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    assign scl_s = s_q.scl_pipe[STAGES-1];
    assign sda_s = s_q.sda_pipe[STAGES-1];

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_prev = scl_s;
        s_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_rise  =  scl_s & ~s_q.scl_prev;
    assign scl_fall  = ~scl_s &  s_q.scl_prev;
    assign start_det =  scl_s &  s_q.scl_prev &  s_q.sda_prev & ~sda_s;
    assign stop_det  =  scl_s &  s_q.scl_prev & ~s_q.sda_prev &  sda_s;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
    import i2c_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data
);
    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              is_addr;
        logic              oe;
        logic              vld;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (start_det) begin
            r_d.st      = RX_BITS;
            r_d.cnt     = '0;
            r_d.is_addr = 1'b1;
            r_d.oe      = 1'b0;
        end else if (stop_det) begin
            r_d.st = RX_IDLE;
            r_d.oe = 1'b0;
        end else begin
            case (r_q.st)
                RX_BITS: begin
                    if (scl_rise && r_q.cnt < CNT_W'(BYTE_W)) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == CNT_W'(BYTE_W)) begin
                        if (r_q.is_addr) begin
                            if (r_q.shreg == TGT_ADDR_BYTE) begin
                                r_d.oe = 1'b1;
                                r_d.st = RX_ACK;
                            end else begin
                                r_d.st = RX_IDLE;
                            end
                        end else begin
                            r_d.oe  = 1'b1;
                            r_d.vld = 1'b1;
                            r_d.st  = RX_ACK;
                        end
                    end
                end
                RX_ACK: begin
                    if (scl_fall) begin
                        r_d.oe      = 1'b0;
                        r_d.st      = RX_BITS;
                        r_d.cnt     = '0;
                        r_d.is_addr = 1'b0;
                    end
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = r_q.oe;
    assign byte_vld  = r_q.vld;
    assign byte_data = r_q.shreg;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
    import i2c_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output ctl_regs_t         regs
);
    ctl_regs_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (byte_vld) begin
            casez (byte_data[7:5])
                3'b00?:  g_d.att_l  = byte_data[ATT_W-1:0];
                3'b01?:  g_d.att_r  = byte_data[ATT_W-1:0];
                3'b100:  g_d.gsel_l = byte_data[FIELD_W-1:0];
                3'b101:  g_d.gsel_r = byte_data[FIELD_W-1:0];
                3'b110:  g_d.pwr    = byte_data[FIELD_W-1:0];
                default: g_d.mode   = byte_data[FIELD_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.att_l  <= ATT_RST;
            g_q.att_r  <= ATT_RST;
            g_q.gsel_l <= GSEL_RST;
            g_q.gsel_r <= GSEL_RST;
            g_q.pwr    <= PWR_RST;
            g_q.mode   <= MODE_RST;
        end else begin
            g_q <= g_d;
        end
    end

    assign regs = g_q;
endmodule

// File: rtl/i2c_ctl_bank.sv
module i2c_ctl_bank
    import i2c_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [5:0] att_l_o,
    output logic [5:0] att_r_o,
    output logic       mute_l_o,
    output logic       mute_r_o,
    output logic [2:0] gain_l_o,
    output logic [1:0] sel_l_o,
    output logic [2:0] gain_r_o,
    output logic [1:0] sel_r_o,
    output logic       dac_pd_o,
    output logic       rpd_o,
    output logic       lpd_o,
    output logic       off_prep_o,
    output logic       ref_pd_o,
    output logic       se_mode_o,
    output logic       mix_l_o,
    output logic       mix_r_o,
    output logic [1:0] fmt_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic byte_vld;
    logic [BYTE_W-1:0] byte_data;
    ctl_regs_t regs;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe_o), .byte_vld(byte_vld), .byte_data(byte_data)
    );

    i2c_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld),
        .byte_data(byte_data), .regs(regs)
    );

    assign att_l_o    = regs.att_l;
    assign att_r_o    = regs.att_r;
    assign mute_l_o   = &regs.att_l;
    assign mute_r_o   = &regs.att_r;
    assign gain_l_o   = regs.gsel_l[4:2];
    assign sel_l_o    = regs.gsel_l[1:0];
    assign gain_r_o   = regs.gsel_r[4:2];
    assign sel_r_o    = regs.gsel_r[1:0];
    assign dac_pd_o   = regs.pwr[4];
    assign rpd_o      = regs.pwr[3];
    assign lpd_o      = regs.pwr[2];
    assign off_prep_o = regs.pwr[1];
    assign ref_pd_o   = regs.pwr[0];
    assign se_mode_o  = regs.mode[4];
    assign mix_l_o    = regs.mode[3];
    assign mix_r_o    = regs.mode[2];
    assign fmt_o      = regs.mode[1:0];
endmodule

// File: rtl/i2c_ctl_bank_chk.sv
module i2c_ctl_bank_chk
    import i2c_ctl_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_s,
    input logic      scl_fall,
    input logic      start_det,
    input logic      byte_vld,
    input logic      sda_oe,
    input ctl_regs_t regs
);
    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_vld) |-> $stable(regs));

    // R3
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R9
    data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> sda_oe);
endmodule

bind i2c_ctl_bank i2c_ctl_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
    .start_det(start_det), .byte_vld(byte_vld), .sda_oe(sda_oe_o), .regs(regs)
);

// File: tb/tb_i2c_ctl_bank.sv
`timescale 1ns/1ps
module tb_i2c_ctl_bank;
    localparam int H = 10;

    logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
    logic sda_oe;
    logic [5:0] att_l, att_r;
    logic mute_l, mute_r;
    logic [2:0] gain_l, gain_r;
    logic [1:0] sel_l, sel_r, fmt;
    logic dac_pd, rpd, lpd, prep, refpd, se, mixl, mixr;
    wire  sda_line = sda_m & ~sda_oe;

    int tests = 0, fails = 0;
    logic [7:0] m [6];

    always #5 clk = ~clk;

    i2c_ctl_bank dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .att_l_o(att_l), .att_r_o(att_r), .mute_l_o(mute_l), .mute_r_o(mute_r),
        .gain_l_o(gain_l), .sel_l_o(sel_l), .gain_r_o(gain_r), .sel_r_o(sel_r),
        .dac_pd_o(dac_pd), .rpd_o(rpd), .lpd_o(lpd), .off_prep_o(prep),
        .ref_pd_o(refpd), .se_mode_o(se), .mix_l_o(mixl), .mix_r_o(mixr), .fmt_o(fmt)
    );

    task automatic hp(); repeat (H) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; hp(); scl = 1; hp(); sda_m = 0; hp(); scl = 0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 0; hp(); scl = 1; hp(); sda_m = 1; hp(); hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hp(); scl = 1; hp(); scl = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1; hp(); scl = 1;
        repeat (H/2) @(negedge clk);
        ack = ~sda_line;
        repeat (H/2) @(negedge clk);
        scl = 0; hp();
    endtask

    function automatic void model_apply(input logic [7:0] b);
        casez (b[7:5])
            3'b00?:  m[0] = b;
            3'b01?:  m[1] = b;
            3'b100:  m[2] = b;
            3'b101:  m[3] = b;
            3'b110:  m[4] = b;
            default: m[5] = b;
        endcase
    endfunction

    function automatic logic [31:0] model_vec();
        return {m[0][5:0], m[1][5:0], m[2][4:0], m[3][4:0], m[4][4:0], m[5][4:0]};
    endfunction

    function automatic logic [31:0] port_vec();
        return {att_l, att_r, gain_l, sel_l, gain_r, sel_r,
                dac_pd, rpd, lpd, prep, refpd, se, mixl, mixr, fmt};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(req, port_vec(), model_vec());
        check(req, {30'd0, mute_l, mute_r},
              {30'd0, m[0][5:0] == 6'h3F, m[1][5:0] == 6'h3F});
    endtask

    task automatic write_tx(input logic [7:0] b, input string req);
        logic a;
        bus_start(); send_byte(8'h88, a);
        check(req, a, 1);
        send_byte(b, a);
        check(req, a, 1);
        model_apply(b);
        bus_stop();
        check_regs(req);
    endtask

    initial begin
        logic a;
        void'($urandom(32'd1234));
        m[0] = 8'h3F; m[1] = 8'h7F; m[2] = 8'h80; m[3] = 8'hA0; m[4] = 8'hDF; m[5] = 8'hE0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check_regs("R1");

        // R5 attenuation, coarse/fine and mute boundary
        write_tx(8'h0A, "R5");
        write_tx(8'h7E, "R5");
        write_tx(8'h7F, "R5");
        write_tx(8'h3E, "R5");
        // R6 gain and line select
        write_tx(8'h8D, "R6");
        write_tx(8'hB6, "R6");
        // R7 power flags
        write_tx(8'hC5, "R7");
        // R8 mode, mix, format
        write_tx(8'hF9, "R8");
        write_tx(8'hE6, "R8");

        // R4 foreign address then a would-be write
        bus_start(); send_byte(8'h90, a); check("R4", a, 0);
        send_byte(8'h00, a); check("R4", a, 0);
        bus_stop(); check_regs("R4");
        // R4 read bit set
        bus_start(); send_byte(8'h89, a); check("R4", a, 0);
        send_byte(8'hC0, a); bus_stop(); check_regs("R4");

        // R2 stray bits with no START
        send_bits(8'h00, 8); send_bits(8'h00, 1); hp(); check_regs("R2");

        // R10 repeated START mid-byte discards the partial byte
        bus_start(); send_byte(8'h88, a); check("R3", a, 1);
        send_bits(8'h00, 5);
        bus_start(); send_byte(8'h88, a); check("R10", a, 1);
        send_byte(8'h15, a); model_apply(8'h15);
        bus_stop(); check_regs("R10");

        // R9 directed: all six registers in one transaction
        bus_start(); send_byte(8'h88, a);
        foreach (m[i]) begin
            logic [7:0] b;
            b = {3'(i == 0 ? 0 : i == 1 ? 2 : i + 2), 5'(i * 5 + 3)};
            if (i < 2) b[5] = 1'b1;
            send_byte(b, a); check("R9", a, 1); model_apply(b);
        end
        bus_stop(); check_regs("R9");

        // R9 random multi-byte transactions, occasional bad address
        for (int t = 0; t < 30; t++) begin
            logic good;
            int n;
            good = ($urandom % 5) != 0;
            n = 1 + ($urandom % 4);
            bus_start();
            send_byte(good ? 8'h88 : 8'h8A, a);
            check("R9", a, good);
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                b = 8'($urandom);
                send_byte(b, a);
                check("R9", a, good);
                if (good) model_apply(b);
            end
            bus_stop();
            check_regs("R9");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule